// File: doc/BRIEF.md
# Divide-Down Organ Tone Generator

This block produces square-wave organ tones for all twelve semitones over six octaves, all derived from one fast master clock. Each semitone owns a programmable counter that makes the highest pitch of that note. A short chain of divide-by-two stages hangs off that counter, and each stage yields the same note one octave lower. This replaces a separate oscillator for every key with one pitch source per note name.

The divide ratio N of each semitone is loaded through a small write port (address and data). The counter toggles its top tone every N master-clock cycles, so the top frequency is f_clk / (2N). A new ratio is held in a staging table and is taken up only when that channel's counter next reloads. A running tone therefore never gets a shortened or stretched half period. The tone bits feed a key-switching network outside this block.

Top module: `tone_gen`

## Requirements
- R1: There are twelve independent channels, addressed 0 (C) to 11 (B). A write to address a changes the pitch of channel a only.
- R2: With effective ratio N, the top output of a channel (octave 0) toggles exactly every N clock cycles. A written ratio of 0 acts as N = 1.
- R3: Output `tone[c*6+k]` is octave k of channel c, where k = 0 is the highest pitch. For k >= 1, stage k toggles on exactly the clock edge where stage k-1 goes from 1 to 0, and on no other edge.
- R4: Every output is a square wave with equal high and low times. Octave k of a channel with ratio N stays high for N*2^k cycles and then low for N*2^k cycles.
- R5: A ratio written to a channel is used from that channel's next reload onward, and never in the middle of a count. A write that lands on the reload edge itself waits for the reload after that.
- R6: Writes with an address of 12 to 15 change no channel.
- R7: Synchronous reset drives every tone output low, clears every counter and sets every ratio to DEF_DIV. After reset is released, the first top-pitch rise of each channel comes on the N-th clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Ratio write strobe |
| wr_addr | input | 4 | Channel index of the write (0..11 valid) |
| wr_data | input | 16 | Divide ratio N |
| tone | output | 72 | Tone bits, index channel*6 + octave |

## Verification
Three properties are checked on every cycle: the octave cascade (a lower stage moves only on, and always on, a falling edge of the stage above); the counter staying below its active ratio and restarting at each top toggle; and the low outputs after reset. What cannot be seen cycle by cycle needs the bench's scenarios. These are the exact N-cycle spacing for each written ratio, a ratio change deferred to the reload, writes to unused addresses leaving every pitch alone, the ratio-zero case and the equal high and low times of the slow octaves. The bench covers them with a cycle-accurate reference model built from the requirements and with direct timing measurements.

// File: rtl/tonegen_pkg.sv
package tonegen_pkg;

    parameter int unsigned DIV_W = 16;

    typedef logic [DIV_W-1:0] ratio_t;

    typedef struct packed {
        ratio_t count;
        ratio_t active;
        logic   tone;
    } osc_state_t;

    function automatic ratio_t eff_ratio(input ratio_t raw);
        return (raw == '0) ? ratio_t'(1) : raw;
    endfunction

endpackage

// File: rtl/tg_ratio_bank.sv
module tg_ratio_bank
    import tonegen_pkg::*;
#(
    parameter int unsigned NOTES   = 12,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DEF_DIV = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  ratio_t            wr_data,
    output ratio_t            ratio_o [NOTES]
);

    typedef logic [NOTES-1:0][DIV_W-1:0] table_t;

    table_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (32'(wr_addr) < NOTES)) begin
            tbl_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q <= {NOTES{ratio_t'(DEF_DIV)}};
        end else begin
            tbl_q <= tbl_d;
        end
    end

    for (genvar g = 0; g < NOTES; g++) begin : g_out
        assign ratio_o[g] = eff_ratio(tbl_q[g]);
    end

endmodule

// File: rtl/tg_top_osc.sv
module tg_top_osc
    import tonegen_pkg::*;
#(
    parameter int unsigned DEF_DIV = 6
) (
    input  logic   clk,
    input  logic   rst,
    input  ratio_t next_ratio,
    output logic   tone_o,
    output logic   fall_o,
    output ratio_t count_o,
    output ratio_t active_o
);

    osc_state_t st_d, st_q;
    logic       reload;

    always_comb begin
        st_d   = st_q;
        reload = (st_q.count == (st_q.active - ratio_t'(1)));
        fall_o = reload && st_q.tone;
        if (reload) begin
            st_d.count  = '0;
            st_d.active = next_ratio;
            st_d.tone   = ~st_q.tone;
        end else begin
            st_d.count  = st_q.count + ratio_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.count  <= '0;
            st_q.active <= eff_ratio(ratio_t'(DEF_DIV));
            st_q.tone   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tone_o   = st_q.tone;
    assign count_o  = st_q.count;
    assign active_o = st_q.active;

endmodule

// File: rtl/tg_octave_chain.sv
module tg_octave_chain #(
    parameter int unsigned OCTAVES = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               top_tone,
    input  logic               top_fall,
    output logic [OCTAVES-1:0] oct_o
);

    localparam int unsigned STAGES = OCTAVES - 1;

    typedef struct packed {
        logic [STAGES-1:0] bits;
    } chain_t;

    chain_t ch_d, ch_q;
    logic [STAGES:0] carry;

    always_comb begin
        ch_d     = ch_q;
        carry[0] = top_fall;
        for (int k = 0; k < STAGES; k++) begin
            carry[k+1] = carry[k] && ch_q.bits[k];
            if (carry[k]) begin
                ch_d.bits[k] = ~ch_q.bits[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign oct_o = {ch_q.bits, top_tone};

endmodule

// File: rtl/tone_gen.sv
module tone_gen
    import tonegen_pkg::*;
#(
    parameter int unsigned NOTES   = 12,
    parameter int unsigned OCTAVES = 6,
    parameter int unsigned DEF_DIV = 6,
    localparam int unsigned ADDR_W = $clog2(NOTES),
    localparam int unsigned NT     = NOTES * OCTAVES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DIV_W-1:0]  wr_data,
    output logic [NT-1:0]     tone
);

    ratio_t                  ratio [NOTES];
    logic [NOTES*DIV_W-1:0]  cnt_flat;
    logic [NOTES*DIV_W-1:0]  act_flat;

    tg_ratio_bank #(
        .NOTES   (NOTES),
        .ADDR_W  (ADDR_W),
        .DEF_DIV (DEF_DIV)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ratio_o (ratio)
    );

    for (genvar c = 0; c < NOTES; c++) begin : g_note
        logic   top_tone;
        logic   top_fall;
        ratio_t cnt;
        ratio_t act;

        tg_top_osc #(
            .DEF_DIV (DEF_DIV)
        ) u_osc (
            .clk        (clk),
            .rst        (rst),
            .next_ratio (ratio[c]),
            .tone_o     (top_tone),
            .fall_o     (top_fall),
            .count_o    (cnt),
            .active_o   (act)
        );

        tg_octave_chain #(
            .OCTAVES (OCTAVES)
        ) u_chain (
            .clk      (clk),
            .rst      (rst),
            .top_tone (top_tone),
            .top_fall (top_fall),
            .oct_o    (tone[c*OCTAVES +: OCTAVES])
        );

        assign cnt_flat[c*DIV_W +: DIV_W] = cnt;
        assign act_flat[c*DIV_W +: DIV_W] = act;
    end

endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
    parameter int unsigned NOTES   = 12,
    parameter int unsigned OCTAVES = 6,
    parameter int unsigned DIV_W   = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NOTES*OCTAVES-1:0] tone,
    input logic [NOTES*DIV_W-1:0]   cnt_flat,
    input logic [NOTES*DIV_W-1:0]   act_flat
);

    p_reset_low_r7: assert property (@(posedge clk) rst |=> (tone == '0))
        else $error("R7: tone not low after reset");

    for (genvar c = 0; c < NOTES; c++) begin : g_c
        localparam int unsigned B = c * OCTAVES;

        // R2: counter always below its active ratio
        p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
            cnt_flat[c*DIV_W +: DIV_W] < act_flat[c*DIV_W +: DIV_W])
            else $error("R2: count out of range");

        // R2: top tone moves only as the counter restarts
        p_top_reload_r2: assert property (@(posedge clk) disable iff (rst)
            (tone[B] != $past(tone[B])) |-> (cnt_flat[c*DIV_W +: DIV_W] == '0))
            else $error("R2: top toggle without reload");

        for (genvar k = 1; k < OCTAVES; k++) begin : g_k
            // R3: a lower stage moves only when the stage above falls
            p_stage_cause_r3: assert property (@(posedge clk) disable iff (rst)
                (tone[B+k] != $past(tone[B+k])) |-> ($past(tone[B+k-1]) && !tone[B+k-1]))
                else $error("R3: stage toggled without falling parent");

            // R3: every fall of the stage above moves this stage
            p_stage_follow_r3: assert property (@(posedge clk) disable iff (rst)
                $fell(tone[B+k-1]) |-> (tone[B+k] != $past(tone[B+k])))
                else $error("R3: stage missed parent fall");
        end
    end

endmodule

bind tone_gen tg_checker #(
    .NOTES   (NOTES),
    .OCTAVES (OCTAVES),
    .DIV_W   (tonegen_pkg::DIV_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tone     (tone),
    .cnt_flat (cnt_flat),
    .act_flat (act_flat)
);

// File: tb/tone_gen_tb.sv
module tone_gen_tb;

    localparam int NOTES   = 12;
    localparam int OCTAVES = 6;
    localparam int DEF_DIV = 6;
    localparam int NT      = NOTES * OCTAVES;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [NT-1:0] tone;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tone_gen #(
        .NOTES   (NOTES),
        .OCTAVES (OCTAVES),
        .DEF_DIV (DEF_DIV)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tone    (tone)
    );

    // ---------------- reference model (driver side of scoreboard) -----
    logic [NT-1:0] exp_q [$];
    int  m_cnt  [NOTES];
    int  m_act  [NOTES];
    int  m_bank [NOTES];
    bit  m_st   [NOTES][OCTAVES];

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        logic [NT-1:0] v;
        if (rst) begin
            for (int c = 0; c < NOTES; c++) begin
                m_cnt[c]  = 0;
                m_act[c]  = DEF_DIV;
                m_bank[c] = DEF_DIV;
                for (int k = 0; k < OCTAVES; k++) m_st[c][k] = 0;
            end
        end else begin
            for (int c = 0; c < NOTES; c++) begin
                if (m_cnt[c] == m_act[c] - 1) begin
                    bit fall;
                    m_cnt[c] = 0;
                    m_act[c] = eff(m_bank[c]);   // R5: old table value
                    fall = m_st[c][0];
                    m_st[c][0] = ~m_st[c][0];
                    for (int k = 1; k < OCTAVES; k++) begin
                        if (fall) begin
                            bit nf;
                            nf = m_st[c][k];
                            m_st[c][k] = ~m_st[c][k];
                            fall = nf;
                        end
                    end
                end else begin
                    m_cnt[c]++;
                end
            end
            if (wr_en && wr_addr < NOTES) m_bank[wr_addr] = int'(wr_data); // R1, R6
        end
        for (int c = 0; c < NOTES; c++)
            for (int k = 0; k < OCTAVES; k++) v[c*OCTAVES+k] = m_st[c][k];
        exp_q.push_back(v);
    end

    // ---------------- monitor ----------------------------------------
    always @(negedge clk) begin
        if (!finished && exp_q.size() > 0) begin
            logic [NT-1:0] e;
            e = exp_q.pop_front();
            n_checks++;
            if (tone !== e) begin
                int bad;
                bad = 0;
                for (int i = NT - 1; i >= 0; i--) if (tone[i] !== e[i]) bad = i;
                n_fail++;
                if (bad % OCTAVES == 0)
                    $display("FAIL R2 ch%0d oct0 at %0t: actual %h expected %h", bad / OCTAVES, $time, tone, e);
                else
                    $display("FAIL R3 ch%0d oct%0d at %0t: actual %h expected %h", bad / OCTAVES, bad % OCTAVES, $time, tone, e);
            end
        end
    end

    // ---------------- driver tasks -----------------------------------
    task automatic write_ratio(input int a, input int n);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(a);
        wr_data = 16'(n);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 outputs low in reset", int'(tone == '0), 1);
        rst = 1'b0;
    endtask

    // R4: measure high and low time of one output bit
    task automatic measure(input int idx, input int exp_half, input string tag);
        int hi;
        int lo;
        hi = 0;
        lo = 0;
        while (tone[idx] !== 1'b0) @(negedge clk);
        while (tone[idx] !== 1'b1) @(negedge clk);
        while (tone[idx] === 1'b1) begin hi++; @(negedge clk); end
        while (tone[idx] === 1'b0) begin lo++; @(negedge clk); end
        check({tag, " high time"}, hi, exp_half);
        check({tag, " low time"}, lo, exp_half);
    endtask

    initial begin
        int t;
        do_reset();
        // R7: first rise of the top pitch on edge DEF_DIV
        t = 0;
        do begin @(negedge clk); t++; end while (tone[0] !== 1'b1 && t < 100);
        check("R7 first top rise", t, DEF_DIV);

        // R1: independent ratio per channel
        for (int c = 0; c < NOTES; c++) write_ratio(c, 3 + c);
        repeat (900) @(negedge clk);

        // R6: unused addresses must leave every channel alone
        write_ratio(12, 2);
        write_ratio(15, 1);
        repeat (400) @(negedge clk);

        // R5: mid-count rewrites deferred to reload
        write_ratio(0, 7);
        write_ratio(0, 4);
        repeat (5) @(negedge clk);
        write_ratio(11, 9);
        repeat (600) @(negedge clk);

        // R2: ratio zero acts as one
        write_ratio(5, 0);
        repeat (50) @(negedge clk);
        measure(5 * OCTAVES + 0, 1, "R2 ratio-zero top");
        measure(5 * OCTAVES + 3, 8, "R4 ratio-zero oct3");

        // R4: equal high/low for slower octaves
        measure(2 * OCTAVES + 2, 5 * 4, "R4 ch2 oct2");
        measure(1 * OCTAVES + 5, 4 * 32, "R4 ch1 oct5");
        measure(0 * OCTAVES + 1, 4 * 2, "R4 ch0 oct1");

        // R7: reset mid-run restores defaults
        do_reset();
        t = 0;
        do begin @(negedge clk); t++; end while (tone[7*OCTAVES] !== 1'b1 && t < 100);
        check("R7 ratio restored after reset", t, DEF_DIV);
        repeat (800) @(negedge clk);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule